// File: doc/BRIEF.md
# Four-slot TDM frame transceiver

This block moves a fixed 125 µs time-division frame over two single-bit serial lines, one for each direction. Each frame holds four 8-bit slots: two bearer octets (B1, B2), a monitor octet, and a control octet. The control octet carries a 2-bit D-channel field, a 4-bit command/indication (C/I) code and two spare bits. The data clock runs at twice the bit rate, so every bit lasts two clock periods. A frame strobe marks the first bit of B1.

On the transmit side, the block takes the slot contents from parallel inputs at each frame start and shifts them out MSB first. On the receive side, it rebuilds the same fields and presents them in parallel with a one-cycle frame strobe. It also picks the stop/go flag out of the received monitor octet. The C/I code is debounced: a new code is adopted only after it arrives in two frames in a row.

A mode input selects where the timing comes from. In generator mode the block divides a reference tick by two to make the data clock and drives both the clock and the frame strobe. In follower mode it takes both from its inputs. All logic runs on one system clock. External lines pass through synchronizers and are turned into edge events.

Top module: `tdm4_xcvr`

## Requirements
- R1: Transmitted frames are 32 bits: B1, B2, monitor, then the control octet, each octet MSB first. The control octet has D in bits 7:6, C/I in bits 5:2, T in bit 1 and E in bit 0.
- R2: The T and E positions of every transmitted control octet are sent as 1.
- R3: The transmit inputs are captured when a frame starts. Changes made during a frame show up only in the next frame.
- R4: A bit lasts two data-clock periods, and txd changes only right after the rising edge that opens a bit. rxd is sampled on the falling edge of the second period of the bit, so its value during the first period has no effect.
- R5: After the last bit of a received frame, rx_b1, rx_b2, rx_mon and rx_d update and rx_valid pulses for one system clock. The received T and E bits have no effect on any output.
- R6: rx_stop_go equals bit 3 of the received monitor octet (bit 0 is the last bit of the octet on the line). It updates together with rx_valid.
- R7: rx_ci changes only when the same C/I code has arrived in two consecutive frames and differs from the current rx_ci. ci_chg pulses for one clock with that rx_valid, and at no other time.
- R8: In generator mode, dclk_out toggles on every ref_tick, so one data-clock period spans two ticks. fsync_out is high for exactly the two data-clock periods of the first B1 bit and rises with that bit's rising edge. timing_drive is 1.
- R9: In follower mode, a frame starts on a rising edge of dclk_in at which fsync_in is high after having been low at the previous rising edge. dclk_out, fsync_out and timing_drive stay 0.
- R10: Until the first frame start after reset, txd stays 1 and rx_valid stays 0.
- R11: During reset: txd is 1; rx_valid, ci_chg, dclk_out, fsync_out and timing_drive are 0; rx_ci is 4'hF.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| gen_mode | input | 1 | 1: generate the line timing, 0: follow external timing |
| ref_tick | input | 1 | One-cycle reference pulse; each pulse toggles the generated data clock |
| dclk_in | input | 1 | External data clock (follower mode) |
| fsync_in | input | 1 | External frame strobe (follower mode) |
| dclk_out | output | 1 | Generated data clock |
| fsync_out | output | 1 | Generated frame strobe |
| timing_drive | output | 1 | High when dclk_out and fsync_out should drive the lines |
| tx_b1 | input | 8 | B1 octet to send |
| tx_b2 | input | 8 | B2 octet to send |
| tx_mon | input | 8 | Monitor octet to send |
| tx_d | input | 2 | D-channel bits to send |
| tx_ci | input | 4 | C/I code to send |
| txd | output | 1 | Serial transmit line |
| rxd | input | 1 | Serial receive line |
| rx_b1 | output | 8 | Received B1 octet |
| rx_b2 | output | 8 | Received B2 octet |
| rx_mon | output | 8 | Received monitor octet |
| rx_d | output | 2 | Received D-channel bits |
| rx_ci | output | 4 | Debounced received C/I code |
| rx_stop_go | output | 1 | Stop/go flag from the received monitor octet |
| rx_valid | output | 1 | One-cycle strobe when a received frame is complete |
| ci_chg | output | 1 | One-cycle strobe when rx_ci takes a new value |

## Verification
The assertions check, on every cycle, the properties that hold for any input:
- rx_valid and ci_chg are single-cycle pulses, and ci_chg never appears without rx_valid.
- rx_ci moves only together with ci_chg.
- txd moves only right after a data-clock rise, and it is idle until the first frame start.
- The generated strobe rises only at slot position zero.
- The timing outputs are quiet in follower mode.

Some behaviour can only be shown by the bench scenarios. These include the exact slot order and bit order on the line, the constant T/E bits, and the capture of transmit inputs at frame start (the bench flips them mid-frame). They also include mid-bit sampling, which the bench tests by putting the wrong value on rxd during the first half of every bit. The remaining scenario-only checks are the two-frame C/I debounce over a sequence with repeats and reversals, and the position and width of the generated strobe.

// File: rtl/tdm4_pkg.sv
package tdm4_pkg;
  localparam int OCT_W      = 8;
  localparam int SLOTS      = 4;
  localparam int D_W        = 2;
  localparam int CI_W       = 4;
  localparam int FRAME_BITS = OCT_W * SLOTS;
  localparam int BIT_W      = $clog2(FRAME_BITS);
  localparam int HALVES     = 2 * FRAME_BITS;     // data-clock periods per frame
  localparam int POS_W      = $clog2(HALVES);
  localparam int SG_BIT     = 3;                  // stop/go position inside the monitor octet

  localparam logic [CI_W-1:0] CI_IDLE = '1;
  localparam logic            T_TX    = 1'b1;
  localparam logic            E_TX    = 1'b1;

  // Packed in line order: the MSB of this struct is the first bit on the wire.
  typedef struct packed {
    logic [OCT_W-1:0] b1;
    logic [OCT_W-1:0] b2;
    logic [OCT_W-1:0] mon;
    logic [D_W-1:0]   d;
    logic [CI_W-1:0]  ci;
    logic             t;
    logic             e;
  } frame_t;
endpackage

// File: rtl/tdm4_timing.sv
module tdm4_timing
  import tdm4_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             gen_mode,
  input  logic             ref_tick,
  input  logic             dclk_in,
  input  logic             fsync_in,
  input  logic             rxd_in,
  output logic             rise_ev,
  output logic             fall_ev,
  output logic             frame_start,
  output logic [POS_W-1:0] pos,
  output logic [POS_W-1:0] nxt_pos,
  output logic             locked,
  output logic             rxd_s,
  output logic             dclk_out,
  output logic             fsync_out,
  output logic             drive
);
  localparam logic [POS_W-1:0] LAST_POS = POS_W'(HALVES - 1);

  logic [SYNC_STAGES-1:0] dclk_sr, fs_sr, rxd_sr;
  logic dclk_s, fs_s;
  logic dclk_prev, fs_prev, dclk_q, fsync_q, mode_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      dclk_sr <= '0;
      fs_sr   <= '0;
      rxd_sr  <= '1;
    end else begin
      dclk_sr <= {dclk_sr[SYNC_STAGES-2:0], dclk_in};
      fs_sr   <= {fs_sr[SYNC_STAGES-2:0], fsync_in};
      rxd_sr  <= {rxd_sr[SYNC_STAGES-2:0], rxd_in};
    end
  end

  assign dclk_s = dclk_sr[SYNC_STAGES-1];
  assign fs_s   = fs_sr[SYNC_STAGES-1];
  assign rxd_s  = rxd_sr[SYNC_STAGES-1];

  always_comb begin
    if (mode_q) begin
      rise_ev     = ref_tick & ~dclk_q;
      fall_ev     = ref_tick & dclk_q;
      frame_start = rise_ev & (pos == LAST_POS);
    end else begin
      rise_ev     = dclk_s & ~dclk_prev;
      fall_ev     = ~dclk_s & dclk_prev;
      frame_start = rise_ev & fs_s & ~fs_prev;
    end
    nxt_pos = frame_start ? '0 : pos + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q    <= 1'b0;
      dclk_prev <= 1'b0;
      fs_prev   <= 1'b0;
      dclk_q    <= 1'b0;
      fsync_q   <= 1'b0;
      pos       <= LAST_POS;
      locked    <= 1'b0;
    end else begin
      mode_q    <= gen_mode;
      dclk_prev <= dclk_s;
      if (!gen_mode)
        dclk_q <= 1'b0;
      else if (mode_q && ref_tick)
        dclk_q <= ~dclk_q;
      if (rise_ev) begin
        pos     <= nxt_pos;
        fs_prev <= fs_s;
        fsync_q <= mode_q && (nxt_pos < POS_W'(2));
      end
      if (!gen_mode)
        fsync_q <= 1'b0;
      if (frame_start)
        locked <= 1'b1;
    end
  end

  assign dclk_out  = dclk_q;
  assign fsync_out = fsync_q;
  assign drive     = mode_q;

  AST_QUIET_FOLLOWER: assert property (@(posedge clk) disable iff (rst)
    !mode_q |-> (!dclk_q && !fsync_q)); // R9

  AST_FSYNC_AT_B1: assert property (@(posedge clk) disable iff (rst)
    $rose(fsync_q) |-> (pos == '0)); // R8
endmodule

// File: rtl/tdm4_tx.sv
module tdm4_tx
  import tdm4_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             rise_ev,
  input  logic             frame_start,
  input  logic             locked,
  input  logic [POS_W-1:0] nxt_pos,
  input  logic [OCT_W-1:0] b1,
  input  logic [OCT_W-1:0] b2,
  input  logic [OCT_W-1:0] mon,
  input  logic [D_W-1:0]   d,
  input  logic [CI_W-1:0]  ci,
  output logic             txd
);
  frame_t fresh, shadow;
  logic [FRAME_BITS-1:0] sh_bits, fresh_bits;
  logic [BIT_W-1:0] bit_sel;

  always_comb begin
    fresh.b1  = b1;
    fresh.b2  = b2;
    fresh.mon = mon;
    fresh.d   = d;
    fresh.ci  = ci;
    fresh.t   = T_TX;
    fresh.e   = E_TX;
    fresh_bits = fresh;
    sh_bits    = shadow;
    bit_sel    = BIT_W'(FRAME_BITS - 1) - nxt_pos[POS_W-1:1];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      shadow <= '0;
      txd    <= 1'b1;
    end else if (frame_start) begin
      shadow <= fresh;
      txd    <= fresh_bits[FRAME_BITS-1];
    end else if (rise_ev && locked && !nxt_pos[0]) begin
      txd <= sh_bits[bit_sel];
    end
  end

  AST_TXD_IDLE: assert property (@(posedge clk) disable iff (rst)
    !locked |-> txd); // R10

  AST_TXD_ON_RISE: assert property (@(posedge clk) disable iff (rst)
    !$stable(txd) |-> $past(rise_ev)); // R4

  AST_FIRST_BIT: assert property (@(posedge clk) disable iff (rst)
    frame_start |=> (txd == $past(b1[OCT_W-1]))); // R1
endmodule

// File: rtl/tdm4_rx.sv
module tdm4_rx
  import tdm4_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             fall_ev,
  input  logic             locked,
  input  logic [POS_W-1:0] pos,
  input  logic             rxd_s,
  output logic [OCT_W-1:0] rx_b1,
  output logic [OCT_W-1:0] rx_b2,
  output logic [OCT_W-1:0] rx_mon,
  output logic [D_W-1:0]   rx_d,
  output logic [CI_W-1:0]  rx_ci,
  output logic             stop_go,
  output logic             valid,
  output logic             ci_chg
);
  // sr holds the first FRAME_BITS-1 bits; frame bit k sits at sr[k-1] when the last bit arrives.
  localparam int B1_HI  = FRAME_BITS - 2;
  localparam int B2_HI  = B1_HI - OCT_W;
  localparam int MON_HI = B2_HI - OCT_W;
  localparam int D_HI   = MON_HI - OCT_W;
  localparam int CI_HI  = D_HI - D_W;
  localparam int SG_POS = MON_HI - OCT_W + 1 + SG_BIT;
  localparam logic [POS_W-1:0] LAST_POS = POS_W'(HALVES - 1);

  logic [FRAME_BITS-2:0] sr;
  logic [CI_W-1:0] cand, new_ci;
  logic take, last;

  assign take   = fall_ev & locked & pos[0];
  assign last   = (pos == LAST_POS);
  assign new_ci = sr[CI_HI -: CI_W];

  always_ff @(posedge clk) begin
    if (rst) begin
      sr      <= '0;
      rx_b1   <= '0;
      rx_b2   <= '0;
      rx_mon  <= '0;
      rx_d    <= '0;
      rx_ci   <= CI_IDLE;
      cand    <= CI_IDLE;
      stop_go <= 1'b0;
      valid   <= 1'b0;
      ci_chg  <= 1'b0;
    end else begin
      valid  <= 1'b0;
      ci_chg <= 1'b0;
      if (take) begin
        sr <= {sr[FRAME_BITS-3:0], rxd_s};
        if (last) begin
          rx_b1   <= sr[B1_HI -: OCT_W];
          rx_b2   <= sr[B2_HI -: OCT_W];
          rx_mon  <= sr[MON_HI -: OCT_W];
          rx_d    <= sr[D_HI -: D_W];
          stop_go <= sr[SG_POS];
          valid   <= 1'b1;
          cand    <= new_ci;
          if (new_ci == cand && new_ci != rx_ci) begin
            rx_ci  <= new_ci;
            ci_chg <= 1'b1;
          end
        end
      end
    end
  end

  AST_VALID_PULSE: assert property (@(posedge clk) disable iff (rst)
    valid |=> !valid); // R5

  AST_CHG_WITH_VALID: assert property (@(posedge clk) disable iff (rst)
    ci_chg |-> valid); // R7

  AST_CI_MOVES_ON_CHG: assert property (@(posedge clk) disable iff (rst)
    !$stable(rx_ci) |-> ci_chg); // R7

  AST_NO_RX_UNLOCKED: assert property (@(posedge clk) disable iff (rst)
    !locked |-> !valid); // R10
endmodule

// File: rtl/tdm4_xcvr.sv
module tdm4_xcvr
  import tdm4_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             gen_mode,
  input  logic             ref_tick,
  input  logic             dclk_in,
  input  logic             fsync_in,
  output logic             dclk_out,
  output logic             fsync_out,
  output logic             timing_drive,
  input  logic [OCT_W-1:0] tx_b1,
  input  logic [OCT_W-1:0] tx_b2,
  input  logic [OCT_W-1:0] tx_mon,
  input  logic [D_W-1:0]   tx_d,
  input  logic [CI_W-1:0]  tx_ci,
  output logic             txd,
  input  logic             rxd,
  output logic [OCT_W-1:0] rx_b1,
  output logic [OCT_W-1:0] rx_b2,
  output logic [OCT_W-1:0] rx_mon,
  output logic [D_W-1:0]   rx_d,
  output logic [CI_W-1:0]  rx_ci,
  output logic             rx_stop_go,
  output logic             rx_valid,
  output logic             ci_chg
);
  logic rise_ev, fall_ev, frame_start, locked, rxd_s;
  logic [POS_W-1:0] pos, nxt_pos;

  tdm4_timing #(.SYNC_STAGES(SYNC_STAGES)) u_timing (
    .clk(clk), .rst(rst), .gen_mode(gen_mode), .ref_tick(ref_tick),
    .dclk_in(dclk_in), .fsync_in(fsync_in), .rxd_in(rxd),
    .rise_ev(rise_ev), .fall_ev(fall_ev), .frame_start(frame_start),
    .pos(pos), .nxt_pos(nxt_pos), .locked(locked), .rxd_s(rxd_s),
    .dclk_out(dclk_out), .fsync_out(fsync_out), .drive(timing_drive)
  );

  tdm4_tx u_tx (
    .clk(clk), .rst(rst), .rise_ev(rise_ev), .frame_start(frame_start),
    .locked(locked), .nxt_pos(nxt_pos),
    .b1(tx_b1), .b2(tx_b2), .mon(tx_mon), .d(tx_d), .ci(tx_ci), .txd(txd)
  );

  tdm4_rx u_rx (
    .clk(clk), .rst(rst), .fall_ev(fall_ev), .locked(locked), .pos(pos),
    .rxd_s(rxd_s), .rx_b1(rx_b1), .rx_b2(rx_b2), .rx_mon(rx_mon),
    .rx_d(rx_d), .rx_ci(rx_ci), .stop_go(rx_stop_go), .valid(rx_valid),
    .ci_chg(ci_chg)
  );
endmodule

// File: tb/test_tdm4_xcvr.sv
module test_tdm4_xcvr;
  logic clk = 1'b0;
  always #2 clk = ~clk;   // 250 MHz

  logic rst, gen_mode, ref_tick, dclk_in, fsync_in, rxd;
  logic dclk_out, fsync_out, timing_drive, txd;
  logic [7:0] tx_b1, tx_b2, tx_mon, rx_b1, rx_b2, rx_mon;
  logic [1:0] tx_d, rx_d;
  logic [3:0] tx_ci, rx_ci;
  logic rx_stop_go, rx_valid, ci_chg;
  logic ref_en;

  tdm4_xcvr i_tdm4_xcvr (
    .clk(clk), .rst(rst), .gen_mode(gen_mode), .ref_tick(ref_tick),
    .dclk_in(dclk_in), .fsync_in(fsync_in), .dclk_out(dclk_out),
    .fsync_out(fsync_out), .timing_drive(timing_drive),
    .tx_b1(tx_b1), .tx_b2(tx_b2), .tx_mon(tx_mon), .tx_d(tx_d), .tx_ci(tx_ci),
    .txd(txd), .rxd(rxd), .rx_b1(rx_b1), .rx_b2(rx_b2), .rx_mon(rx_mon),
    .rx_d(rx_d), .rx_ci(rx_ci), .rx_stop_go(rx_stop_go), .rx_valid(rx_valid),
    .ci_chg(ci_chg)
  );

  int n_chk = 0;
  int n_err = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  typedef struct {
    logic [7:0] b1, b2, mon;
    logic [1:0] d;
    logic [3:0] ci;
    logic       chg;
    logic       sg;
  } rx_exp_t;

  rx_exp_t     rx_q[$];
  logic [31:0] tx_q[$];
  logic [3:0]  m_lat, m_prev;

  function automatic logic [31:0] mk(input logic [7:0] b1, b2, mon,
                                     input logic [1:0] d, input logic [3:0] ci,
                                     input logic t, e);
    return {b1, b2, mon, d, ci, t, e};
  endfunction

  // Model of R5/R6/R7 for one received frame
  function automatic void push_rx(input logic [31:0] w);
    rx_exp_t x;
    x.b1  = w[31:24];
    x.b2  = w[23:16];
    x.mon = w[15:8];
    x.d   = w[7:6];
    x.sg  = w[8 + 3];
    x.chg = (w[5:2] == m_prev) && (w[5:2] != m_lat);
    if (x.chg) m_lat = w[5:2];
    m_prev = w[5:2];
    x.ci = m_lat;
    rx_q.push_back(x);
  endfunction

  function automatic void set_tx(input logic [31:0] w);
    {tx_b1, tx_b2, tx_mon, tx_d, tx_ci} = w[31:2];
  endfunction

  // Monitor: pops expected receive results as the design produces them
  initial begin
    forever begin
      @(negedge clk);
      if (rx_valid) begin
        if (rx_q.size() == 0) chk(1'b0, "R10", "unexpected rx_valid", 1, 0);
        else begin
          rx_exp_t e;
          e = rx_q.pop_front();
          chk(rx_b1 == e.b1, "R5", "rx_b1", rx_b1, e.b1);
          chk(rx_b2 == e.b2, "R5", "rx_b2", rx_b2, e.b2);
          chk(rx_mon == e.mon, "R5", "rx_mon", rx_mon, e.mon);
          chk(rx_d == e.d, "R5", "rx_d", rx_d, e.d);
          chk(rx_stop_go == e.sg, "R6", "rx_stop_go", rx_stop_go, e.sg);
          chk(rx_ci == e.ci, "R7", "rx_ci", rx_ci, e.ci);
          chk(ci_chg == e.chg, "R7", "ci_chg", ci_chg, e.chg);
        end
      end else if (ci_chg && !rst) begin
        chk(1'b0, "R7", "ci_chg without rx_valid", 1, 0);
      end
    end
  end

  // Reference tick every 8 system clocks while enabled
  initial begin
    int c = 0;
    ref_tick = 1'b0;
    forever begin
      @(negedge clk);
      if (ref_en) begin
        c++;
        ref_tick = (c % 8 == 0);
      end else begin
        c = 0;
        ref_tick = 1'b0;
      end
    end
  end

  // Follower-mode frame: bench drives dclk_in (16-clock period) and fsync_in
  task automatic run_f(input logic [31:0] txw, input logic [31:0] rxw, input bit sync);
    logic [31:0] got = '0;
    logic        early = 1'b0;
    logic [31:0] exp_tx;
    if (sync) begin
      set_tx(txw);
      tx_q.push_back({txw[31:2], 2'b11});
      push_rx(rxw);
    end
    for (int p = 0; p < 64; p++) begin
      @(negedge clk);
      dclk_in  = 1'b1;
      fsync_in = sync && (p < 2);
      rxd      = p[0] ? rxw[31 - p/2] : ~rxw[31 - p/2];   // R4: wrong value in first half
      if (p == 32 && sync) set_tx(~txw);                  // R3: late change
      repeat (8) @(negedge clk);
      dclk_in = 1'b0;
      if (p == 10) chk(!dclk_out && !fsync_out && !timing_drive, "R9", "timing outputs idle",
                       {dclk_out, fsync_out, timing_drive}, 0);
      if (!p[0]) early = txd;
      else begin
        got[31 - p/2] = txd;
        if (sync) chk(txd == early, "R4", "txd stable across bit", txd, early);
        else      chk(txd === 1'b1, "R10", "txd idle before lock", txd, 1);
      end
      repeat (7) @(negedge clk);
    end
    if (sync) begin
      exp_tx = tx_q.pop_front();
      chk(got == exp_tx, "R1", "tx frame", got, exp_tx);
      chk(got[1:0] == 2'b11, "R2", "tx T/E bits", got[1:0], 2'b11);
      chk(got[15:0] == exp_tx[15:0], "R3", "tx bits after mid-frame change", got[15:0], exp_tx[15:0]);
    end
  endtask

  // Generator-mode frame: bench follows dclk_out
  task automatic run_g(input logic [31:0] txw, input logic [31:0] rxw);
    logic [31:0] got = '0;
    logic        early = 1'b0;
    logic [31:0] exp_tx;
    realtime     t_last = 0;
    set_tx(txw);
    tx_q.push_back({txw[31:2], 2'b11});
    push_rx(rxw);
    for (int p = 0; p < 64; p++) begin
      @(posedge dclk_out);
      if (p == 1) chk(($realtime - t_last) == 64.0, "R8", "data clock period ns",
                      longint'($realtime - t_last), 64);
      t_last = $realtime;
      #1;
      chk(fsync_out == (p < 2), "R8", "fsync_out position", fsync_out, (p < 2));
      if (p == 5) chk(timing_drive == 1'b1, "R8", "timing_drive", timing_drive, 1);
      rxd = p[0] ? rxw[31 - p/2] : ~rxw[31 - p/2];
      if (p == 32) set_tx(~txw);
      @(negedge dclk_out);
      #1;
      if (!p[0]) early = txd;
      else begin
        got[31 - p/2] = txd;
        chk(txd == early, "R4", "txd stable across bit (gen)", txd, early);
      end
    end
    exp_tx = tx_q.pop_front();
    chk(got == exp_tx, "R1", "tx frame (gen)", got, exp_tx);
    chk(got[1:0] == 2'b11, "R2", "tx T/E bits (gen)", got[1:0], 2'b11);
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++;
    n_err++;
    $display("FAIL R5 watchdog: actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    rst = 1'b1; gen_mode = 1'b0; ref_en = 1'b0;
    dclk_in = 1'b0; fsync_in = 1'b0; rxd = 1'b1;
    set_tx('0);
    m_lat = 4'hF; m_prev = 4'hF;
    repeat (6) @(posedge clk);
    @(negedge clk);
    // R11 reset state
    chk(txd == 1'b1, "R11", "txd in reset", txd, 1);
    chk(!rx_valid && !ci_chg, "R11", "strobes in reset", {rx_valid, ci_chg}, 0);
    chk(rx_ci == 4'hF, "R11", "rx_ci in reset", rx_ci, 4'hF);
    chk(!dclk_out && !fsync_out && !timing_drive, "R11", "timing outputs in reset",
        {dclk_out, fsync_out, timing_drive}, 0);
    rst = 1'b0;

    // Follower mode: unsynchronised clocks first (R10), then framed traffic
    run_f(32'h0, 32'h1234_5678, 1'b0);
    run_f(mk(8'hA5, 8'h3C, 8'h81, 2'b10, 4'h3, 1'b0, 1'b0), mk(8'h96, 8'h0F, 8'h08, 2'b01, 4'h3, 1'b0, 1'b1), 1'b1);
    run_f(mk(8'h01, 8'h80, 8'hFF, 2'b01, 4'hC, 1'b0, 1'b1), mk(8'h5A, 8'hF0, 8'hF7, 2'b11, 4'h3, 1'b1, 1'b0), 1'b1);
    run_f(mk(8'hFF, 8'h00, 8'h00, 2'b11, 4'h0, 1'b1, 1'b0), mk(8'h00, 8'hFF, 8'h00, 2'b00, 4'h5, 1'b0, 1'b0), 1'b1);
    run_f(mk(8'h6E, 8'h91, 8'h42, 2'b00, 4'h9, 1'b0, 1'b0), mk(8'hC3, 8'h3C, 8'hFF, 2'b10, 4'h3, 1'b1, 1'b1), 1'b1);
    run_f(mk(8'h10, 8'h20, 8'h30, 2'b10, 4'h7, 1'b1, 1'b1), mk(8'h11, 8'h22, 8'h33, 2'b01, 4'h3, 1'b0, 1'b1), 1'b1);
    run_f(mk(8'h55, 8'hAA, 8'h0F, 2'b01, 4'hA, 1'b0, 1'b0), mk(8'hE7, 8'h18, 8'h44, 2'b11, 4'hC, 1'b1, 1'b0), 1'b1);
    run_f(mk(8'h80, 8'h01, 8'hF0, 2'b11, 4'h5, 1'b0, 1'b1), mk(8'h7E, 8'h81, 8'hBB, 2'b00, 4'hC, 1'b0, 1'b0), 1'b1);
    run_f(mk(8'h3C, 8'hC3, 8'h99, 2'b00, 4'hF, 1'b1, 1'b0), mk(8'h24, 8'h42, 8'h08, 2'b10, 4'hF, 1'b1, 1'b1), 1'b1);
    run_f(mk(8'hDE, 8'hAD, 8'hBE, 2'b10, 4'h1, 1'b0, 1'b0), mk(8'hBE, 8'hEF, 8'hF7, 2'b01, 4'hF, 1'b0, 1'b0), 1'b1);
    repeat (40) @(negedge clk);
    chk(rx_q.size() == 0, "R5", "all follower frames delivered", rx_q.size(), 0);

    // Generator mode
    rst = 1'b1; gen_mode = 1'b1;
    repeat (6) @(negedge clk);
    m_lat = 4'hF; m_prev = 4'hF;
    rst = 1'b0;
    @(negedge clk);
    ref_en = 1'b1;
    run_g(mk(8'hC9, 8'h36, 8'h5A, 2'b01, 4'h6, 1'b0, 1'b0), mk(8'h81, 8'h7E, 8'h08, 2'b10, 4'h6, 1'b0, 1'b1));
    run_g(mk(8'h12, 8'hED, 8'hA5, 2'b10, 4'h2, 1'b1, 1'b1), mk(8'h3F, 8'hC0, 8'h00, 2'b01, 4'h6, 1'b1, 1'b0));
    run_g(mk(8'h00, 8'hFF, 8'h0F, 2'b11, 4'hB, 1'b0, 1'b1), mk(8'hAA, 8'h55, 8'hF7, 2'b11, 4'h9, 1'b0, 1'b0));
    run_g(mk(8'hF0, 8'h0F, 8'h77, 2'b00, 4'h4, 1'b1, 1'b0), mk(8'h5B, 8'hB5, 8'h88, 2'b00, 4'h9, 1'b1, 1'b1));
    repeat (80) @(negedge clk);
    chk(rx_q.size() == 0, "R5", "all generator frames delivered", rx_q.size(), 0);
    finish_run();
  end
endmodule